// File: doc/BRIEF.md
# Cascaded Wide Programmable Divider Chain

This block builds a wide synchronous binary counter out of identical narrow counter slices, four 8-bit slices giving 32 bits by default. Each slice raises an active-low flag while it holds all ones. A slice above the lowest one advances only when the flags of every slice below it are low. No single wide adder is used: each slice keeps a narrow incrementer, and the carry between slices is formed by OR-ing the active-low flags.

In count mode the whole chain counts up and wraps from all ones to zero. In divide mode, the cycle after every slice reads all ones at once, the chain reloads a wide preset, so the chain flag goes low for one clock in every N clocks, with N = 2^W − preset (W is the total width). A synchronous load input copies the preset into the chain at any time. This is how a divide sequence is started without first counting through the full range. A global count enable stalls the whole chain.

Top module: `wide_div_chain`

## Requirements
- R1: While rst_ni is low, count_o is zero and chain_tc_no is high, starting at once without waiting for a clock. After rst_ni rises the chain leaves reset on the second clock edge, and count_o stays zero until then.
- R2: In count mode (div_mode_i = 0), with cnt_en_i = 1 and load_i = 0, count_o increases by one on each clock and wraps from all ones to zero.
- R3: With cnt_en_i = 0 and load_i = 0, count_o holds its value in either mode. In divide mode this includes the all-ones state, which then does not reload.
- R4: The 8-bit field k of count_o (bits 8k+7..8k, k ≥ 1) changes without load_i only on a clock where every lower field held all ones in the cycle before.
- R5: chain_tc_no is low exactly while every bit of count_o is one.
- R6: In divide mode (div_mode_i = 1), with cnt_en_i = 1 and load_i = 0, a clock taken while count_o is all ones loads preset_i into count_o. In every other state the count increments as in R2.
- R7: In divide mode with an unchanging preset P, chain_tc_no goes low for one clock once every N = 2^W − P clocks, for N from 2 to 2^W.
- R8: load_i = 1 loads preset_i into count_o on the next clock, whatever the mode and the count enable.
- R9: In count mode, preset_i has no effect on count_o unless load_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en_i | input | 1 | Global count enable, active high |
| div_mode_i | input | 1 | 0 = count mode, 1 = divide mode (reload on chain terminal count) |
| load_i | input | 1 | Synchronous load of preset_i into all slices, highest priority |
| preset_i | input | SLICE_W*N_SLICES | Wide preset value |
| count_o | output | SLICE_W*N_SLICES | Wide count |
| chain_tc_no | output | 1 | Active-low chain terminal count, low while the whole count is all ones |

## Verification
The bench runs a three-slice chain. A free count in count mode crosses the boundary between the first and second slices, while preset_i changes on every clock; this shows whether the carry gating is correct and whether the preset leaks into count mode. Loads placed just below the second-to-third slice boundary and just below the full wrap show whether the OR of flags reaches beyond two slices. Enable patterns that stall the chain on all ones in either mode separate a global stall from a stall of the lowest slice alone. Divide ratios from 2 up to several thousand, some inside one slice and some across slice boundaries, are timed between chain flag pulses to confirm the reload value and the pulse spacing.

// File: rtl/wdc_pkg.sv
`timescale 1ns/1ps
package wdc_pkg;
  localparam int unsigned DEF_SLICE_W  = 8;
  localparam int unsigned DEF_N_SLICES = 4;
  localparam int unsigned SYNC_STAGES  = 2;

  typedef enum logic {
    MODE_COUNT  = 1'b0,
    MODE_DIVIDE = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/wdc_rst_sync.sv
`timescale 1ns/1ps
module wdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdc_slice.sv
`timescale 1ns/1ps
module wdc_slice #(
  parameter int unsigned SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_ni,
  input  logic               load_ni,
  input  logic [SLICE_W-1:0] preset_i,
  output logic [SLICE_W-1:0] q_o,
  output logic               tc_no
);
  logic [SLICE_W-1:0] q_q;
  logic [SLICE_W-1:0] q_d;
  logic               upd;

  always_comb begin
    q_d = q_q;
    upd = 1'b0;
    if (!load_ni) begin
      q_d = preset_i;
      upd = 1'b1;
    end else if (!cnt_en_ni) begin
      q_d = q_q + {{(SLICE_W-1){1'b0}}, 1'b1};
      upd = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q_o   = q_q;
  assign tc_no = ~(&q_q);
endmodule

// File: rtl/wdc_cascade_gate.sv
`timescale 1ns/1ps
module wdc_cascade_gate #(
  parameter int unsigned N_SLICES = 4
) (
  input  logic [N_SLICES-1:0] tc_ni,
  input  logic                cnt_en_i,
  input  logic                div_en_i,
  input  logic                load_i,
  output logic [N_SLICES-1:0] ce_no,
  output logic                load_no,
  output logic                chain_tc_no
);
  logic [N_SLICES:0] block_n;
  logic              any_tc_high;

  assign block_n[0] = ~cnt_en_i;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_prefix
    assign ce_no[k]     = block_n[k];
    assign block_n[k+1] = block_n[k] | tc_ni[k];
  end

  assign any_tc_high = |tc_ni;
  assign chain_tc_no = any_tc_high;
  assign load_no     = ~(load_i | (div_en_i & cnt_en_i & ~any_tc_high));
endmodule

// File: rtl/wide_div_chain.sv
`timescale 1ns/1ps
module wide_div_chain #(
  parameter int unsigned SLICE_W  = wdc_pkg::DEF_SLICE_W,
  parameter int unsigned N_SLICES = wdc_pkg::DEF_N_SLICES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cnt_en_i,
  input  logic                        div_mode_i,
  input  logic                        load_i,
  input  logic [SLICE_W*N_SLICES-1:0] preset_i,
  output logic [SLICE_W*N_SLICES-1:0] count_o,
  output logic                        chain_tc_no
);
  import wdc_pkg::*;

  localparam int unsigned W = SLICE_W * N_SLICES;

  chain_mode_e         mode;
  logic                div_en;
  logic                rst_sync_n;
  logic [N_SLICES-1:0] tc_n;
  logic [N_SLICES-1:0] ce_n;
  logic                load_n;

  assign mode   = chain_mode_e'(div_mode_i);
  assign div_en = (mode == MODE_DIVIDE);

  wdc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  wdc_cascade_gate #(.N_SLICES(N_SLICES)) u_gate (
    .tc_ni       (tc_n),
    .cnt_en_i    (cnt_en_i),
    .div_en_i    (div_en),
    .load_i      (load_i),
    .ce_no       (ce_n),
    .load_no     (load_n),
    .chain_tc_no (chain_tc_no)
  );

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    wdc_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .cnt_en_ni (ce_n[k]),
      .load_ni   (load_n),
      .preset_i  (preset_i[k*SLICE_W +: SLICE_W]),
      .q_o       (count_o[k*SLICE_W +: SLICE_W]),
      .tc_no     (tc_n[k])
    );
  end

  logic [W-1:0] unused_w;
  assign unused_w = count_o;
endmodule

// File: rtl/wdc_checker.sv
`timescale 1ns/1ps
module wdc_checker #(
  parameter int unsigned SLICE_W  = 8,
  parameter int unsigned N_SLICES = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rst_sync_ni,
  input logic                        cnt_en_i,
  input logic                        div_mode_i,
  input logic                        load_i,
  input logic [SLICE_W*N_SLICES-1:0] preset_i,
  input logic [SLICE_W*N_SLICES-1:0] count_o,
  input logic                        chain_tc_no
);
  localparam int unsigned W = SLICE_W * N_SLICES;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (count_o == '0 && chain_tc_no));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (cnt_en_i && !load_i && !(div_mode_i && (&count_o)))
      |=> (count_o == $past(count_o) + {{(W-1){1'b0}}, 1'b1}));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (!cnt_en_i && !load_i) |=> $stable(count_o));

  for (genvar k = 1; k < N_SLICES; k++) begin : g_carry
    p_carry_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
      (!load_i && !(&count_o[k*SLICE_W-1:0]))
        |=> $stable(count_o[k*SLICE_W +: SLICE_W]));
  end

  p_tc_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_tc_no == !(&count_o)));

  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (cnt_en_i && div_mode_i && !load_i && (&count_o))
      |=> (count_o == $past(preset_i)));

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    load_i |=> (count_o == $past(preset_i)));
endmodule

bind wide_div_chain wdc_checker #(
  .SLICE_W  (SLICE_W),
  .N_SLICES (N_SLICES)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_sync_ni (rst_sync_n),
  .cnt_en_i    (cnt_en_i),
  .div_mode_i  (div_mode_i),
  .load_i      (load_i),
  .preset_i    (preset_i),
  .count_o     (count_o),
  .chain_tc_no (chain_tc_no)
);

// File: tb/wide_div_chain_tb_top.sv
`timescale 1ns/1ps
module wide_div_chain_tb_top;
  localparam int unsigned SW = 8;
  localparam int unsigned NS = 3;
  localparam int unsigned W  = SW * NS;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic         div;
  logic         load;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic         tc_n;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  bit    cmp_on  = 0;
  string cur_req = "R1";
  int    cyc     = 0;
  int    tc_pulses = 0;
  int    last_tc   = 0;
  int    last_gap  = 0;
  logic [W-1:0] m_cnt;

  always #2 clk = ~clk;

  wide_div_chain #(.SLICE_W(SW), .N_SLICES(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .div_mode_i(div),
    .load_i(load), .preset_i(preset), .count_o(count), .chain_tc_no(tc_n)
  );

  // behavioural reference: a plain W-bit counter
  always @(posedge clk) begin
    if (!rst_n)    m_cnt <= '0;
    else if (load) m_cnt <= preset;
    else if (en)   m_cnt <= (div && m_cnt == ALL1) ? preset : m_cnt + 1'b1;
  end

  task automatic check_eq(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [W-1:0] e;
    cyc++;
    if (cmp_on) begin
      e = rst_n ? m_cnt : '0;
      check_eq(cur_req, count, e);
      check_eq({cur_req, "/R5 tc"}, {{(W-1){1'b0}}, tc_n}, {{(W-1){1'b0}}, (e != ALL1)});
    end
    if (tc_n === 1'b0) begin
      last_gap = cyc - last_tc;
      last_tc  = cyc;
      tc_pulses++;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic measure_ratio(int n);
    int start;
    cur_req = "R6";
    div = 1'b1; en = 1'b1;
    preset = ALL1 - W'(n) + 1'b1;
    load = 1'b1; step(1); load = 1'b0;
    start = tc_pulses;
    while (tc_pulses < start + 3) step(1);
    check_eq("R7 divide period", W'(last_gap), W'(n));
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; div = 1'b0; load = 1'b0; preset = '0;
    #1;
    cmp_on = 1;
    step(4);
    check_eq("R1 reset count", count, '0);
    check_eq("R1 reset tc", {{(W-1){1'b0}}, tc_n}, {{(W-1){1'b0}}, 1'b1});
    rst_n = 1'b1;
    step(3);
    check_eq("R1 after release", count, '0);

    // R2 / R9: free count across slice 0->1, preset churning
    cur_req = "R2/R9";
    en = 1'b1;
    for (int i = 0; i < 600; i++) begin
      preset = W'(i * 32'h0001_3579);
      step(1);
    end
    // R3: stall
    cur_req = "R3";
    en = 1'b0;
    step(20);
    // R2/R3: irregular enable
    cur_req = "R2/R3 gated";
    for (int i = 0; i < 300; i++) begin
      en = (i % 3) != 0;
      step(1);
    end

    // R8 load with enable low, then R4 crossing slice 1->2
    cur_req = "R8";
    en = 1'b0; preset = 24'h00FFF0; load = 1'b1; step(1); load = 1'b0;
    step(1);
    check_eq("R8 load en low", count, 24'h00FFF0);
    cur_req = "R4";
    en = 1'b1; step(40);
    // R2 full wrap through all slices
    cur_req = "R2 wrap";
    preset = 24'hFFFFF0; load = 1'b1; step(1); load = 1'b0;
    step(40);
    check_eq("R2 wrapped", count, 24'h000018);

    // R6/R7 divide ratios, inside and across slices
    measure_ratio(2);
    measure_ratio(3);
    measure_ratio(113);
    measure_ratio(256);
    measure_ratio(257);
    measure_ratio(1000);
    measure_ratio(4099);

    // R8 load while running in divide mode
    cur_req = "R8 run";
    preset = 24'h123456; load = 1'b1; step(1); load = 1'b0;
    check_eq("R8 load running", count, 24'h123456);

    // R3: stall at all ones in divide mode, no reload
    cur_req = "R3 div stall";
    preset = ALL1 - 24'd4; load = 1'b1; step(1); load = 1'b0;
    while (count !== ALL1) step(1);
    en = 1'b0;
    step(10);
    check_eq("R3 held at all ones", count, ALL1);
    en = 1'b1; step(1);
    check_eq("R6 reload after stall", count, ALL1 - 24'd4);

    // R1 asynchronous reset mid-run
    cur_req = "R1 async";
    step(3);
    rst_n = 1'b0;
    #1;
    check_eq("R1 async clear", count, '0);
    step(3);
    rst_n = 1'b1;
    en = 1'b0;
    step(4);
    check_eq("R1 post release", count, '0);

    cmp_on = 0;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule